// File: doc/BRIEF.md
# Interrupt Cause and Enable Unit

This block keeps the interrupt cause register and the interrupt enable register of a host storage controller, and turns their combination into an interrupt towards the host. Two internal events feed it. A completion event sets the completion cause bit. A message event sets the message cause bit. The host reaches both registers through a 32-bit word-addressed register port: read returns, write-one-to-clear on the cause register, and full replacement on the enable register.

The interrupt is asserted whenever the cause and enable registers share a set bit. A mode pin selects how that condition reaches the host. In level mode it drives a level line that tracks the condition. In message mode it drives one-cycle pulses: the block re-evaluates the condition after every change to either register and sends a pulse on each re-evaluation that finds it true. Every cause write also pulses a retry request, which tells the completion logic to try again to post any completions it is holding. An adapter reset input clears the cause register.

Top module: `irq_cause_unit`

## Requirements
- R1: A completion event sets cause bit 0 and a message event sets cause bit 1; each is visible in the cause register on the cycle after the event.
- R2: A write to the cause register (word address 0) clears every cause bit written as one and keeps every bit written as zero.
- R3: A write to the enable register (word address 1) replaces all 32 bits of the enable register.
- R4: In level mode (`msg_mode_i` low), `irq_level_o` is high exactly when cause AND enable is non-zero, one cycle after the register change. In message mode `irq_level_o` stays low.
- R5: In message mode, `irq_pulse_o` is high for one cycle, one cycle after each re-evaluation, if cause AND enable is then non-zero. A re-evaluation is any event, cause write, enable write or adapter reset. There is no pulse when the condition is false, when nothing was re-evaluated, or in level mode.
- R6: `retry_o` pulses for one cycle, on the cycle after every cause-register write.
- R7: A read request returns `rd_valid_o` high on the next cycle. `rd_data_o` then holds the value the addressed register had when the request was made: address 0 gives the cause register, address 1 the enable register, and any other address gives zero.
- R8: When an event and a cause-register clear of the same bit occur in the same cycle, the event wins and the bit ends up set.
- R9: `adapter_rst_i` clears the cause register to zero. It overrides events in the same cycle and leaves the enable register unchanged.
- R10: Writes to word addresses other than 0 and 1 change neither register and produce no retry pulse.
- R11: After `rst_n` both registers are zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adapter_rst_i | input | 1 | Clears the cause register |
| msg_mode_i | input | 1 | 0 selects the level output, 1 selects the pulse output |
| cmpl_evt_i | input | 1 | Completion event |
| msg_evt_i | input | 1 | Message event |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read word address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| irq_level_o | output | 1 | Level interrupt line |
| irq_pulse_o | output | 1 | Message interrupt pulse |
| retry_o | output | 1 | Retry request for completion posting |

## Verification
All results are registered, so each one is due one cycle after the edge that captures its stimulus. This covers the cause and enable values, the level line, the pulse, the retry request and the read data. The bench drives inputs on the falling edge. On the next falling edge it compares every output against values its model computed from the stimulus it has just applied. It holds the mode pin steady until that comparison is done. Read data is predicted from the model's register values before the update, because a read returns the state from before the edge.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_EN    = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [1:0] addr);
    case (addr)
      2'd0:    decode_addr = SEL_CAUSE;
      2'd1:    decode_addr = SEL_EN;
      default: decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int DATA_W   = 32,
  parameter int CMPL_BIT = 0,
  parameter int MSG_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adapter_rst,
  input  logic              cmpl_evt,
  input  logic              msg_evt,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] cause_q,
  output logic              retry_q
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] CMPL_M = ONE << CMPL_BIT;
  localparam logic [DATA_W-1:0] MSG_M  = ONE << MSG_BIT;

  logic [DATA_W-1:0] set_v, kept_v;

  always_comb begin
    set_v  = (cmpl_evt ? CMPL_M : '0) | (msg_evt ? MSG_M : '0);
    kept_v = clr_en ? (cause_q & ~clr_mask) : cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      retry_q <= 1'b0;
    end else begin
      retry_q <= clr_en;
      if (adapter_rst) cause_q <= '0;
      else             cause_q <= kept_v | set_v;
    end
  end

  a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !cmpl_evt && !msg_evt && !adapter_rst) |=> ((cause_q & $past(clr_mask)) == '0));
  a_r9_adapter_clear: assert property (@(posedge clk) disable iff (!rst_n)
    adapter_rst |=> (cause_q == '0));
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_evt && !adapter_rst) |=> cause_q[CMPL_BIT]);
  a_r1_cause_bits_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~(CMPL_M | MSG_M)) == '0);
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= wdata;
  end

  a_r3_replace: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (en_q == $past(wdata)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en_q));
endmodule

// File: rtl/irq_signal_out.sv
module irq_signal_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_mode,
  input  logic              reeval,
  input  logic [DATA_W-1:0] cause,
  input  logic [DATA_W-1:0] en,
  output logic              irq_level,
  output logic              irq_pulse
);
  logic reeval_q;
  logic cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reeval_q <= 1'b0;
    else        reeval_q <= reeval;
  end

  always_comb begin
    cond      = |(cause & en);
    irq_level = !msg_mode && cond;
    irq_pulse = msg_mode && reeval_q && cond;
  end

  a_r5_pulse_after_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(reeval));
  a_r4_one_output: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_level && irq_pulse));
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int CMPL_BIT = 0,
  parameter int MSG_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adapter_rst_i,
  input  logic              msg_mode_i,
  input  logic              cmpl_evt_i,
  input  logic              msg_evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_level_o,
  output logic              irq_pulse_o,
  output logic              retry_o
);
  import irq_cause_pkg::*;

  reg_sel_e          wr_sel, rd_sel;
  logic              wr_cause, wr_en_reg, reeval;
  logic [DATA_W-1:0] cause_q, en_q;

  always_comb begin
    wr_sel    = decode_addr(wr_addr_i[1:0]);
    rd_sel    = decode_addr(rd_addr_i[1:0]);
    wr_cause  = wr_en_i && (wr_sel == SEL_CAUSE);
    wr_en_reg = wr_en_i && (wr_sel == SEL_EN);
    reeval    = wr_cause || wr_en_reg || cmpl_evt_i || msg_evt_i || adapter_rst_i;
  end

  irq_cause_reg #(.DATA_W(DATA_W), .CMPL_BIT(CMPL_BIT), .MSG_BIT(MSG_BIT)) u_cause (
    .clk(clk), .rst_n(rst_n), .adapter_rst(adapter_rst_i),
    .cmpl_evt(cmpl_evt_i), .msg_evt(msg_evt_i),
    .clr_en(wr_cause), .clr_mask(wr_data_i),
    .cause_q(cause_q), .retry_q(retry_o)
  );

  irq_enable_reg #(.DATA_W(DATA_W)) u_enable (
    .clk(clk), .rst_n(rst_n), .we(wr_en_reg), .wdata(wr_data_i), .en_q(en_q)
  );

  irq_signal_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode_i), .reeval(reeval),
    .cause(cause_q), .en(en_q),
    .irq_level(irq_level_o), .irq_pulse(irq_pulse_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        case (rd_sel)
          SEL_CAUSE: rd_data_o <= cause_q;
          SEL_EN:    rd_data_o <= en_q;
          default:   rd_data_o <= '0;
        endcase
      end
    end
  end

  a_r6_retry_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause |=> retry_o);
  a_r6_retry_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> $past(wr_cause));
  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
endmodule

// File: tb/sim_irq_cause_unit.sv
module sim_irq_cause_unit;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic adapter_rst_i = 0, msg_mode_i = 0, cmpl_evt_i = 0, msg_evt_i = 0;
  logic wr_en_i = 0, rd_en_i = 0;
  logic [1:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [31:0] wr_data_i = 0;
  logic rd_valid_o, irq_level_o, irq_pulse_o, retry_o;
  logic [31:0] rd_data_o;

  int checks = 0, errors = 0;
  logic [31:0] m_cause = 0, m_en = 0;
  logic e_level = 0, e_pulse = 0, e_retry = 0, e_rdv = 0;
  logic [31:0] e_rdd = 0;
  string e_tag = "R7";

  always #(CLK_PER/2) clk = ~clk;

  irq_cause_unit u0 (
    .clk(clk), .rst_n(rst_n), .adapter_rst_i(adapter_rst_i), .msg_mode_i(msg_mode_i),
    .cmpl_evt_i(cmpl_evt_i), .msg_evt_i(msg_evt_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .irq_level_o(irq_level_o), .irq_pulse_o(irq_pulse_o), .retry_o(retry_o)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] next_cause(input logic [31:0] c, input logic ar, input logic ce,
                                             input logic me, input logic wc, input logic [31:0] wd);
    logic [31:0] v;
    v = wc ? (c & ~wd) : c;
    v = v | {30'd0, me, ce};
    return ar ? 32'd0 : v;
  endfunction

  task automatic compare_outputs();
    check(irq_level_o === e_level, "R4", {31'd0, irq_level_o}, {31'd0, e_level});
    check(irq_pulse_o === e_pulse, "R5", {31'd0, irq_pulse_o}, {31'd0, e_pulse});
    check(retry_o === e_retry, "R6", {31'd0, retry_o}, {31'd0, e_retry});
    check(rd_valid_o === e_rdv, "R7", {31'd0, rd_valid_o}, {31'd0, e_rdv});
    if (e_rdv) check(rd_data_o === e_rdd, e_tag, rd_data_o, e_rdd);
  endtask

  task automatic step(input logic ar, input logic md, input logic ce, input logic me,
                      input logic we, input logic [1:0] wa, input logic [31:0] wd,
                      input logic re, input logic [1:0] ra, input string tag);
    logic wc, wn, rv;
    logic [31:0] nc, ne;
    @(negedge clk);
    compare_outputs();
    adapter_rst_i = ar; msg_mode_i = md; cmpl_evt_i = ce; msg_evt_i = me;
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; rd_en_i = re; rd_addr_i = ra;
    wc = we && (wa == 2'd0);
    wn = we && (wa == 2'd1);
    rv = wc || wn || ce || me || ar;
    nc = next_cause(m_cause, ar, ce, me, wc, wd);
    ne = wn ? wd : m_en;
    e_rdv = re;
    e_rdd = (ra == 2'd0) ? m_cause : ((ra == 2'd1) ? m_en : 32'd0);
    e_tag = tag;
    e_level = !md && ((nc & ne) != 0);
    e_pulse = md && rv && ((nc & ne) != 0);
    e_retry = wc;
    m_cause = nc;
    m_en = ne;
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state at the ports
    check({irq_level_o, irq_pulse_o, retry_o, rd_valid_o} === 4'b0, "R11",
          {28'd0, irq_level_o, irq_pulse_o, retry_o, rd_valid_o}, 32'd0);
    check(rd_data_o === 32'd0, "R11", rd_data_o, 32'd0);
    step(0,0,0,0,0,0,0,1,0,"R11");
    step(0,0,0,0,0,0,0,1,1,"R11");
    // R1: each event sets its own bit
    step(0,0,1,0,0,0,0,0,0,"R1");
    step(0,0,0,0,0,0,0,1,0,"R1");
    step(0,0,0,1,0,0,0,0,0,"R1");
    step(0,0,0,0,0,0,0,1,0,"R1");
    // R3: enable write replaces the whole value
    step(0,0,0,0,1,1,32'hA5A5_0003,0,0,"R3");
    step(0,0,0,0,1,1,32'h0000_0002,1,1,"R3");
    step(0,0,0,0,0,0,0,1,1,"R3");
    // R2: clear bit 1 only, bit 0 stays
    step(0,0,0,0,1,0,32'h0000_0002,0,0,"R2");
    step(0,0,0,0,0,0,0,1,0,"R2");
    // R8: event and clear of the same bit in one cycle
    step(0,0,1,0,1,0,32'h0000_0001,0,0,"R8");
    step(0,0,0,0,0,0,0,1,0,"R8");
    // R10: unmapped address writes are ignored
    step(0,0,0,0,1,2,32'hFFFF_FFFF,0,0,"R10");
    step(0,0,0,0,1,3,32'hFFFF_FFFF,1,1,"R10");
    step(0,0,0,0,0,0,0,1,0,"R10");
    step(0,0,0,0,0,0,0,1,2,"R10");
    // R9: adapter reset beats events, enable kept
    step(0,0,0,0,1,1,32'h3,0,0,"R9");
    step(1,0,1,1,0,0,0,0,0,"R9");
    step(0,0,0,0,0,0,0,1,0,"R9");
    step(0,0,0,0,0,0,0,1,1,"R9");
    // R5: message mode pulses
    step(0,1,1,0,0,0,0,0,0,"R5");
    step(0,1,0,0,0,0,0,0,0,"R5");
    step(0,1,0,0,1,1,32'h1,0,0,"R5");
    step(0,1,0,0,1,0,32'h1,0,0,"R5");
    step(0,1,0,1,0,0,0,0,0,"R5");
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd;
      wd = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h3);
      step(($urandom % 16) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 2) == 0, 2'($urandom), wd,
           ($urandom % 2) == 0, 2'($urandom), "R7");
    end
    step(0,0,0,0,0,0,0,0,0,"R7");
    @(negedge clk);
    compare_outputs();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule